// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Level Flags

This block is a single-clock first-in first-out buffer whose depth is two to the power of a size parameter. Besides the usual full and empty indications it drives two level flags. An almost-full flag is raised when the occupancy reaches a programmable upper level. An almost-empty flag is raised when the occupancy drops to a programmable lower level. Both levels are loaded together from one 32-bit configuration word. Surrounding logic can use these flags to start a refill or a drain burst early, before the hard limits are reached.

A synchronous soft-clear input empties the buffer at any time, including after a read was attempted on an empty buffer. It keeps the programmed levels. The head entry is always visible on the read data port, so a pop consumes the word that is shown in the same cycle. All four flags are registered. Each flag shows the occupancy that results from the operations accepted at a clock edge, starting with that same edge.

Top module: `thresh_fifo`

## Requirements
- R1: When `rst_n` is low at a clock edge, the buffer becomes empty, `empty` and `prog_empty` read 1, `full` and `prog_full` read 0, the upper level becomes DEPTH and the lower level becomes 0.
- R2: Words leave in the order they were accepted. While `empty` is 0, `rd_data` shows the oldest stored word.
- R3: `full` is 1 exactly when the occupancy equals DEPTH = 2^SIZE_W (16 to 128 for SIZE_W from 4 to 7). `empty` is 1 exactly when the occupancy is 0.
- R4: A push while the buffer is full is dropped: it does not change the occupancy or any stored word.
- R5: A pop while the buffer is empty is dropped and leaves the occupancy at 0.
- R6: `prog_full` is 1 exactly when the occupancy is greater than or equal to the upper level, which is bits [15:0] of the configuration word.
- R7: `prog_empty` is 1 exactly when the occupancy is less than or equal to the lower level, which is bits [31:16] of the configuration word.
- R8: When `cfg_we` is high at an edge, both levels are loaded from `cfg_word`, and the flags are evaluated against the new levels from that edge on.
- R9: When `clr` is high at an edge, the occupancy becomes 0 and the flags show an empty buffer. `clr` takes priority over a push or pop in the same cycle, keeps the programmed levels, and works the same after a dropped pop.
- R10: A push and a pop in the same cycle are both accepted when the buffer is neither full nor empty, and the occupancy stays the same. When the buffer is full only the pop is taken. When it is empty only the push is taken.
- R11: All four flags change at the clock edge that accepts the push, pop, clear or level load that alters them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous soft clear of the contents |
| wr_en | input | 1 | Push request |
| wr_data | input | DATA_W | Word to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | DATA_W | Oldest stored word |
| cfg_we | input | 1 | Load strobe for the level word |
| cfg_word | input | 32 | Levels: [31:16] lower, [15:0] upper |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| prog_full | output | 1 | Occupancy at or above the upper level |
| prog_empty | output | 1 | Occupancy at or below the lower level |

## Verification
A push and a pop can arrive in the same cycle, and which of them is accepted depends on the occupancy at that edge. The bench brings the buffer to every occupancy from 0 to DEPTH and issues one combined push and pop at each level. It then drains the buffer and compares every word and the exact point where `empty` rises against an arithmetic model. The same pattern is used to check that a clear overrides a push issued in the same cycle.

// File: rtl/tf_pkg.sv
// Shared types for the threshold FIFO.
// Assumes the configuration word is 32 bits with the lower level in the upper half.
package tf_pkg;
    // Level configuration word, upper half first
    typedef struct packed {
        logic [15:0] lo_lvl;
        logic [15:0] hi_lvl;
    } tf_lvl_t;
endpackage

// File: rtl/tf_store.sv
// Register-based storage array for the threshold FIFO.
// One register per entry is written when the accepted push addresses it.
// The read side is a plain multiplexer on the read pointer.
// Assumes push acceptance has already been qualified upstream.
module tf_store #(
    parameter int SIZE_W = 4,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << SIZE_W
) (
    input  logic              clk,
    input  logic              push_ok,
    input  logic [SIZE_W-1:0] wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SIZE_W-1:0] rd_ptr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot_v [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DATA_W-1:0] q;
        // capture the pushed word into this slot when addressed
        always_ff @(posedge clk) begin
            if (push_ok && wr_ptr == SIZE_W'(i)) q <= wr_data;
        end
        assign slot_v[i] = q;
    end

    // present the head entry
    assign rd_data = slot_v[rd_ptr];
endmodule

// File: rtl/tf_ptrs.sv
// Pointer and occupancy tracking for the threshold FIFO.
// Qualifies pushes against a full buffer and pops against an empty one.
// Soft clear has priority over both.
// Provides the next occupancy so the flag stage can register it.
module tf_ptrs #(
    parameter int SIZE_W = 4,
    localparam int DEPTH = 1 << SIZE_W,
    localparam int CNT_W = SIZE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              push_ok,
    output logic [SIZE_W-1:0] wr_ptr,
    output logic [SIZE_W-1:0] rd_ptr,
    output logic [CNT_W-1:0]  cnt_next
);
    logic [CNT_W-1:0] cnt_q;
    logic             pop_ok;

    // qualify requests and form the next occupancy
    always_comb begin
        push_ok  = wr_en && !clr && (cnt_q != CNT_W'(DEPTH));
        pop_ok   = rd_en && !clr && (cnt_q != '0);
        cnt_next = clr ? '0 : cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end

    // advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            cnt_q <= cnt_next;
        end
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    // R4
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(DEPTH) && wr_en && !rd_en && !clr) |=> ($stable(wr_ptr) && cnt_q == CNT_W'(DEPTH)));
    // R5
    no_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && rd_en && !clr) |=> $stable(rd_ptr));
    // R9
    clear_ptrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && wr_ptr == rd_ptr));
endmodule

// File: rtl/tf_flags.sv
// Level registers and registered status flags for the threshold FIFO.
// Evaluates the four flags from the next occupancy and the next level word.
// Each flag therefore moves on the same edge as the change that causes it.
// Assumes the occupancy never exceeds DEPTH.
module tf_flags
    import tf_pkg::*;
#(
    parameter int SIZE_W = 4,
    localparam int DEPTH = 1 << SIZE_W,
    localparam int CNT_W = SIZE_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_word,
    output logic             full,
    output logic             empty,
    output logic             prog_full,
    output logic             prog_empty
);
    tf_lvl_t     lvl_q, lvl_d;
    logic [15:0] occ16;

    // select the level word in force after this edge
    always_comb begin
        lvl_d = cfg_we ? tf_lvl_t'(cfg_word) : lvl_q;
        occ16 = 16'(cnt_next);
    end

    // hold levels and register flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q      <= '{lo_lvl: 16'd0, hi_lvl: 16'(DEPTH)};
            full       <= 1'b0;
            empty      <= 1'b1;
            prog_full  <= 1'b0;
            prog_empty <= 1'b1;
        end else begin
            lvl_q      <= lvl_d;
            full       <= (cnt_next == CNT_W'(DEPTH));
            empty      <= (cnt_next == '0);
            prog_full  <= (occ16 >= lvl_d.hi_lvl);
            prog_empty <= (occ16 <= lvl_d.lo_lvl);
        end
    end

    // R3
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    // R6
    pfull_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && lvl_q.hi_lvl <= 16'(DEPTH)) |-> prog_full);
    // R7
    pempty_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> prog_empty);
endmodule

// File: rtl/thresh_fifo.sv
// Top of the threshold FIFO: synchronous buffer of 2^SIZE_W words.
// Drives full, empty and two programmable level flags.
// Assumes SIZE_W in 4..7, one clock domain and a synchronous active-low reset.
module thresh_fifo #(
    parameter int SIZE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_word,
    output logic              full,
    output logic              empty,
    output logic              prog_full,
    output logic              prog_empty
);
    localparam int CNT_W = SIZE_W + 1;

    logic              push_ok;
    logic [SIZE_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt_next;

    tf_ptrs #(.SIZE_W(SIZE_W)) ptrs_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .rd_en(rd_en),
        .push_ok(push_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .cnt_next(cnt_next)
    );

    tf_store #(.SIZE_W(SIZE_W), .DATA_W(DATA_W)) store_i (
        .clk(clk), .push_ok(push_ok), .wr_ptr(wr_ptr), .wr_data(wr_data),
        .rd_ptr(rd_ptr), .rd_data(rd_data)
    );

    tf_flags #(.SIZE_W(SIZE_W)) flags_i (
        .clk(clk), .rst_n(rst_n), .cnt_next(cnt_next), .cfg_we(cfg_we),
        .cfg_word(cfg_word), .full(full), .empty(empty),
        .prog_full(prog_full), .prog_empty(prog_empty)
    );

    // R10
    both_at_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && rd_en && !clr) |=> !full);
    // R9
    clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !full));
endmodule

// File: tb/thresh_fifo_tb_top.sv
module thresh_fifo_tb_top;
    localparam int SIZE_W = 4;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << SIZE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              cfg_we = 1'b0;
    logic [31:0]       cfg_word = '0;
    logic              full, empty, prog_full, prog_empty;

    int checks = 0;
    int errors = 0;
    logic [DATA_W-1:0] mdl[$];
    int hi_lvl = DEPTH;
    int lo_lvl = 0;

    always #4 clk = ~clk;

    thresh_fifo #(.SIZE_W(SIZE_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .cfg_we(cfg_we), .cfg_word(cfg_word),
        .full(full), .empty(empty), .prog_full(prog_full), .prog_empty(prog_empty)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // compare all four flags with the model occupancy
    task automatic chk_flags(input string req);
        int n = mdl.size();
        logic [3:0] exp_f, act_f;
        exp_f = {n == DEPTH, n == 0, n >= hi_lvl, n <= lo_lvl};
        act_f = {full, empty, prog_full, prog_empty};
        check(act_f == exp_f, req, int'(act_f), int'(exp_f));
    endtask

    // one cycle of stimulus; called and returns at a falling edge
    task automatic cyc(input bit we, input logic [DATA_W-1:0] d, input bit re,
                       input bit cl, input bit cw, input logic [31:0] cfg);
        bit pop_ok, push_ok;
        wr_en = we; wr_data = d; rd_en = re; clr = cl; cfg_we = cw; cfg_word = cfg;
        pop_ok  = re && !cl && mdl.size() > 0;
        push_ok = we && !cl && mdl.size() < DEPTH;
        if (pop_ok) check(rd_data == mdl[0], "R2 head word", int'(rd_data), int'(mdl[0]));
        @(posedge clk);
        if (cl) mdl.delete();
        if (pop_ok) void'(mdl.pop_front());
        if (push_ok) mdl.push_back(d);
        if (cw) begin
            hi_lvl = int'(cfg[15:0]);
            lo_lvl = int'(cfg[31:16]);
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; clr = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic set_lvls(input int lo, input int hi);
        cyc(0, 0, 0, 0, 1, {16'(lo), 16'(hi)});
        chk_flags("R8 level load");
    endtask

    // fill past full then drain past empty, checking every step
    task automatic sweep(input int seed);
        for (int i = 0; i <= DEPTH; i++) begin
            cyc(1, DATA_W'(seed + i * 7), 0, 0, 0, 0);
            chk_flags(i == DEPTH ? "R4 push at full" : "R6 R7 R11 fill");
        end
        for (int i = 0; i <= DEPTH; i++) begin
            cyc(0, 0, 1, 0, 0, 0);
            chk_flags(i == DEPTH ? "R5 pop at empty" : "R3 R6 R7 drain");
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset pattern with default levels
        chk_flags("R1 reset");

        // R6 R7 level sweeps over several level pairs
        sweep(3);
        set_lvls(5, 11);
        sweep(40);
        set_lvls(DEPTH, 0);
        sweep(91);
        set_lvls(DEPTH - 1, 1);
        sweep(150);

        // R10 combined push and pop at every occupancy
        set_lvls(4, 12);
        for (int k = 0; k <= DEPTH; k++) begin
            cyc(0, 0, 0, 1, 0, 0);
            for (int j = 0; j < k; j++) cyc(1, DATA_W'(k * 16 + j), 0, 0, 0, 0);
            cyc(1, DATA_W'(200 + k), 1, 0, 0, 0);
            chk_flags("R10 combined op");
            while (mdl.size() > 0) begin
                cyc(0, 0, 1, 0, 0, 0);
                chk_flags("R10 drain");
            end
        end

        // R9 clear after dropped pop, with data, and against a push
        cyc(0, 0, 1, 0, 0, 0);
        for (int j = 0; j < 9; j++) cyc(1, DATA_W'(j + 60), 0, 0, 0, 0);
        chk_flags("R9 pre-clear");
        cyc(1, 8'hAA, 0, 1, 0, 0);
        chk_flags("R9 clear beats push");
        check(empty == 1'b1, "R9 empty after clear", int'(empty), 1);
        for (int j = 0; j < 12; j++) begin
            cyc(1, DATA_W'(j + 100), 0, 0, 0, 0);
            chk_flags("R9 levels kept");
        end
        check(rd_data == 8'd100, "R9 head after clear", int'(rd_data), 100);

        // R1 reset again while holding data restores levels
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        mdl.delete();
        hi_lvl = DEPTH;
        lo_lvl = 0;
        chk_flags("R1 reset with data");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule